// File: doc/BRIEF.md
# Light-Load Burst Mode Controller

This block is the mode controller of a fixed-frequency flyback primary controller. It decides when the converter drops into a burst standby mode at light load, how switching is gated while that mode is active, and when the mode ends. All analog decisions reach it as digital threshold flags from the feedback comparators. A programmable clock-cycle count takes the place of the capacitor-defined blanking window.

Burst mode is entered only when the low-feedback flag stays asserted for a whole blanking window. Inside burst mode, switching follows a two-level hysteresis on the feedback flags. This gives a sawtooth between the start and stop levels. A high-feedback flag ends burst mode at once, with no window. The same blanking window also times overload: the expiry output goes to the neighbouring auto-restart logic. Every flag passes through a two-flop synchronizer before use.

Top module: `burst_mode_ctrl`

## Requirements
- R1: With `windowLen` = N, `burstFlag` rises exactly N+3 clock edges after `fbLowRaw` is asserted and held. If `fbLowRaw` is held for fewer than N+1 cycles, burst mode is never entered.
- R2: Deasserting `fbLowRaw` for even one cycle before the window expires restarts the window from zero. Burst mode then needs a new uninterrupted hold of N+1 cycles.
- R3: On entry, `burstFlag` is 1, `switchEn` is 0 and `ssClamp` is 1.
- R4: In burst mode, `fbStartRaw` (feedback above the restart level) sets `switchEn` to 1 on the third clock edge. `fbStopRaw` (feedback down at the stop level) clears it on the third edge. Outside burst mode, `switchEn` is 1 and these two flags have no effect.
- R5: `reducedLimit` (select the reduced current-limit threshold) equals `burstFlag` at all times.
- R6: `fbHighRaw` ends burst mode on the third clock edge, whatever `windowLen` is. At that point `burstFlag`, `reducedLimit` and `ssClamp` are 0 and `switchEn` is 1. `fbHighRaw` takes priority over `fbStartRaw`.
- R7: `blankDone` is armed by a synchronized `fbHighRaw` in any mode, or by a synchronized `fbLowRaw` in normal mode. After the arming flag is asserted and held, `blankDone` rises exactly N+2 clock edges later. It is 0 one edge before that.
- R8: A synchronous active-low `rstN` puts the block in normal mode. While `rstN` is low, the outputs are `burstFlag` = 0, `switchEn` = 1, `reducedLimit` = 0, `ssClamp` = 0 and `blankDone` = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Synchronous active-low reset |
| windowLen | input | CNT_W | Blanking window length in clock cycles |
| fbLowRaw | input | 1 | Feedback below the light-load level |
| fbStartRaw | input | 1 | Feedback above the burst restart level |
| fbStopRaw | input | 1 | Feedback down at the burst stop level |
| fbHighRaw | input | 1 | Feedback above the overload level |
| burstFlag | output | 1 | Burst standby mode active |
| switchEn | output | 1 | Internal bias on, switching enabled |
| reducedLimit | output | 1 | Select the reduced current-limit threshold |
| ssClamp | output | 1 | Request to clamp the soft-start node |
| blankDone | output | 1 | Blanking window expired (shared with auto-restart) |

## Verification
The hardest case to reach is the edge of the entry window. Hold lengths of N and N+1 cycles give opposite results, and every flag first crosses two synchronizer flops. The stimulus sweeps every window length in a small range against every hold length around N+1. The expected outcome is computed as hold >= N+1. A second sweep checks the exact rise edge N+3. The restart case adds a one-cycle gap between two holds, each one cycle too short.

// File: rtl/burst_pkg.sv
package burst_pkg;
  typedef enum logic [1:0] {
    MODE_NORMAL   = 2'd0,
    MODE_BURST_OFF = 2'd1,
    MODE_BURST_ON  = 2'd2
  } modeState_t;

  typedef struct packed {
    logic armWindow;
  } ctrlStrobes_t;

  localparam int NUM_FLAGS = 4;
  localparam int FLAG_LOW   = 0;
  localparam int FLAG_START = 1;
  localparam int FLAG_STOP  = 2;
  localparam int FLAG_HIGH  = 3;
endpackage

// File: rtl/flag_sync.sv
module flag_sync #(
  parameter int WIDTH = 4,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [WIDTH-1:0] rawIn,
  output logic [WIDTH-1:0] syncOut
);
  genvar b;
  generate
    for (b = 0; b < WIDTH; b++) begin : g_bit
      logic [STAGES-1:0] chain;
      always_ff @(posedge clk) begin
        if (!rstN) chain <= '0;
        else       chain <= {chain[STAGES-2:0], rawIn[b]};
      end
      assign syncOut[b] = chain[STAGES-1];
    end
  endgenerate
endmodule

// File: rtl/blank_window.sv
module blank_window
  import burst_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [CNT_W-1:0] windowLen,
  input  ctrlStrobes_t     strobes,
  output logic             windowDone
);
  logic [CNT_W-1:0] count;
  logic             reached;

  assign reached = (count >= windowLen);

  always_ff @(posedge clk) begin
    if (!rstN)                 count <= '0;
    else if (!strobes.armWindow) count <= '0;
    else if (!reached)         count <= count + 1'b1;
  end

  assign windowDone = strobes.armWindow && reached;
endmodule

// File: rtl/burst_fsm.sv
module burst_fsm
  import burst_pkg::*;
(
  input  logic         clk,
  input  logic         rstN,
  input  logic         fbLow,
  input  logic         fbStart,
  input  logic         fbStop,
  input  logic         fbHigh,
  input  logic         windowDone,
  output ctrlStrobes_t strobes,
  output logic         burstFlag,
  output logic         switchEn,
  output logic         reducedLimit,
  output logic         ssClamp
);
  modeState_t state, nextState;

  always_comb begin
    nextState = state;
    unique case (state)
      MODE_NORMAL:    if (fbLow && windowDone) nextState = MODE_BURST_OFF;
      MODE_BURST_OFF: if (fbHigh) nextState = MODE_NORMAL;
                      else if (fbStart) nextState = MODE_BURST_ON;
      MODE_BURST_ON:  if (fbHigh) nextState = MODE_NORMAL;
                      else if (fbStop) nextState = MODE_BURST_OFF;
      default:        nextState = MODE_NORMAL;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) state <= MODE_NORMAL;
    else       state <= nextState;
  end

  always_comb begin
    strobes = '0;
    strobes.armWindow = fbHigh || (fbLow && state == MODE_NORMAL);
  end

  assign burstFlag    = (state != MODE_NORMAL);
  assign switchEn     = (state != MODE_BURST_OFF);
  assign reducedLimit = burstFlag;
  assign ssClamp      = burstFlag;
endmodule

// File: rtl/burst_mode_ctrl.sv
module burst_mode_ctrl
  import burst_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [CNT_W-1:0] windowLen,
  input  logic             fbLowRaw,
  input  logic             fbStartRaw,
  input  logic             fbStopRaw,
  input  logic             fbHighRaw,
  output logic             burstFlag,
  output logic             switchEn,
  output logic             reducedLimit,
  output logic             ssClamp,
  output logic             blankDone
);
  logic [NUM_FLAGS-1:0] rawFlags, syncFlags;
  ctrlStrobes_t         strobes;
  logic                 windowDone;

  always_comb begin
    rawFlags             = '0;
    rawFlags[FLAG_LOW]   = fbLowRaw;
    rawFlags[FLAG_START] = fbStartRaw;
    rawFlags[FLAG_STOP]  = fbStopRaw;
    rawFlags[FLAG_HIGH]  = fbHighRaw;
  end

  flag_sync #(.WIDTH(NUM_FLAGS), .STAGES(2)) sync_i (
    .clk(clk), .rstN(rstN), .rawIn(rawFlags), .syncOut(syncFlags)
  );

  blank_window #(.CNT_W(CNT_W)) window_i (
    .clk(clk), .rstN(rstN), .windowLen(windowLen),
    .strobes(strobes), .windowDone(windowDone)
  );

  burst_fsm fsm_i (
    .clk(clk), .rstN(rstN),
    .fbLow(syncFlags[FLAG_LOW]), .fbStart(syncFlags[FLAG_START]),
    .fbStop(syncFlags[FLAG_STOP]), .fbHigh(syncFlags[FLAG_HIGH]),
    .windowDone(windowDone), .strobes(strobes),
    .burstFlag(burstFlag), .switchEn(switchEn),
    .reducedLimit(reducedLimit), .ssClamp(ssClamp)
  );

  assign blankDone = windowDone;
endmodule

// File: rtl/burst_mode_ctrl_chk.sv
module burst_mode_ctrl_chk (
  input logic clk,
  input logic rstN,
  input logic burstFlag,
  input logic switchEn,
  input logic reducedLimit,
  input logic ssClamp,
  input logic blankDone
);
  assert_entry_after_window_R1: assert property (@(posedge clk) disable iff (!rstN)
    $rose(burstFlag) |-> $past(blankDone));

  assert_entry_outputs_R3: assert property (@(posedge clk) disable iff (!rstN)
    $rose(burstFlag) |-> (!switchEn && ssClamp));

  assert_switch_outside_burst_R4: assert property (@(posedge clk) disable iff (!rstN)
    !burstFlag |-> switchEn);

  assert_limit_follows_flag_R5: assert property (@(posedge clk) disable iff (!rstN)
    (reducedLimit == burstFlag) && (ssClamp == burstFlag));

  assert_exit_restores_R6: assert property (@(posedge clk) disable iff (!rstN)
    $fell(burstFlag) |-> (switchEn && !reducedLimit && !ssClamp));

  assert_reset_state_R8: assert property (@(posedge clk) disable iff (!rstN)
    $past(!rstN) |-> (!burstFlag && switchEn && !blankDone));
endmodule

bind burst_mode_ctrl burst_mode_ctrl_chk chk_i (
  .clk(clk), .rstN(rstN), .burstFlag(burstFlag), .switchEn(switchEn),
  .reducedLimit(reducedLimit), .ssClamp(ssClamp), .blankDone(blankDone)
);

// File: tb/burst_mode_ctrl_tb_top.sv
module burst_mode_ctrl_tb_top;
  localparam int CNT_W = 8;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [CNT_W-1:0] windowLen = '0;
  logic fbLowRaw = 0, fbStartRaw = 0, fbStopRaw = 0, fbHighRaw = 0;
  logic burstFlag, switchEn, reducedLimit, ssClamp, blankDone;

  int vectors = 0;
  int misses = 0;
  bit finished = 0;

  always #5 clk = ~clk;

  burst_mode_ctrl #(.CNT_W(CNT_W)) dut_i (
    .clk(clk), .rstN(rstN), .windowLen(windowLen),
    .fbLowRaw(fbLowRaw), .fbStartRaw(fbStartRaw), .fbStopRaw(fbStopRaw),
    .fbHighRaw(fbHighRaw), .burstFlag(burstFlag), .switchEn(switchEn),
    .reducedLimit(reducedLimit), .ssClamp(ssClamp), .blankDone(blankDone)
  );

  task automatic step(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic chk(input logic actual, input logic expected, input string req);
    vectors++;
    if (actual !== expected) begin
      misses++;
      $display("FAIL %s: actual %0b expected %0b at %0t", req, actual, expected, $time);
    end
  endtask

  task automatic doReset();
    rstN = 0; fbLowRaw = 0; fbStartRaw = 0; fbStopRaw = 0; fbHighRaw = 0;
    step(3);
    rstN = 1;
    step(1);
  endtask

  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
    $finish;
  endtask

  initial begin
    #(200000 * 10);
    if (!finished) begin
      misses++;
      vectors++;
      $display("FAIL watchdog: actual hung expected done");
      summary();
    end
  end

  initial begin
    @(negedge clk);
    // R8: outputs while held in reset
    step(2);
    chk(burstFlag, 0, "R8 burstFlag");
    chk(switchEn, 1, "R8 switchEn");
    chk(reducedLimit, 0, "R8 reducedLimit");
    chk(ssClamp, 0, "R8 ssClamp");
    chk(blankDone, 0, "R8 blankDone");

    // R1: entry decision swept over window length and hold length
    for (int n = 0; n <= 5; n++) begin
      for (int d = 1; d <= n + 3; d++) begin
        doReset();
        windowLen = n[CNT_W-1:0];
        fbLowRaw = 1;
        step(d);
        fbLowRaw = 0;
        step(n + 4);
        chk(burstFlag, (d >= n + 1), "R1 entry iff hold>=N+1");
      end
    end

    // R1: exact entry edge N+3
    for (int n = 0; n <= 7; n++) begin
      doReset();
      windowLen = n[CNT_W-1:0];
      fbLowRaw = 1;
      step(n + 2);
      chk(burstFlag, 0, "R1 not before N+3");
      step(1);
      chk(burstFlag, 1, "R1 at N+3");
      fbLowRaw = 0;
    end

    // R2: a one-cycle gap restarts the window
    doReset();
    windowLen = 4;
    fbLowRaw = 1; step(4);
    fbLowRaw = 0; step(1);
    fbLowRaw = 1; step(4);
    fbLowRaw = 0; step(6);
    chk(burstFlag, 0, "R2 gap restarts window");
    fbLowRaw = 1; step(7);
    chk(burstFlag, 1, "R2 fresh full hold enters");
    fbLowRaw = 0;

    // R7: overload window expiry timing
    for (int n = 0; n <= 5; n++) begin
      doReset();
      windowLen = n[CNT_W-1:0];
      fbHighRaw = 1; fbStartRaw = 1;
      step(n + 1);
      chk(blankDone, 0, "R7 before N+2");
      step(1);
      chk(blankDone, 1, "R7 at N+2");
      chk(burstFlag, 0, "R7 no burst on overload");
    end

    // R3, R4, R5: entry outputs and hysteresis
    doReset();
    windowLen = 2;
    fbLowRaw = 1; step(5);
    chk(burstFlag, 1, "R3 burstFlag");
    chk(switchEn, 0, "R3 switchEn");
    chk(ssClamp, 1, "R3 ssClamp");
    chk(reducedLimit, 1, "R5 reducedLimit in burst");
    fbLowRaw = 0;
    for (int k = 0; k < 3; k++) begin
      fbStartRaw = 1; step(2);
      chk(switchEn, 0, "R4 start not before third edge");
      step(1);
      chk(switchEn, 1, "R4 start at third edge");
      fbStartRaw = 0; fbStopRaw = 1; step(2);
      chk(switchEn, 1, "R4 stop not before third edge");
      step(1);
      chk(switchEn, 0, "R4 stop at third edge");
      chk(reducedLimit, 1, "R5 reducedLimit during sawtooth");
      fbStopRaw = 0; step(1);
    end

    // R6: immediate exit with a long window, priority over start flag
    windowLen = 200;
    fbHighRaw = 1; fbStartRaw = 1;
    step(2);
    chk(burstFlag, 1, "R6 not before third edge");
    step(1);
    chk(burstFlag, 0, "R6 burstFlag cleared");
    chk(switchEn, 1, "R6 switchEn");
    chk(reducedLimit, 0, "R6 reducedLimit");
    chk(ssClamp, 0, "R6 ssClamp");
    fbHighRaw = 0; fbStartRaw = 0;

    // R4: stop flag ignored in normal mode
    fbStopRaw = 1; step(6);
    chk(switchEn, 1, "R4 stop ignored in normal");
    chk(burstFlag, 0, "R4 stays normal");
    fbStopRaw = 0;

    // R8: reset in the middle of burst
    windowLen = 1;
    fbLowRaw = 1; step(6);
    chk(burstFlag, 1, "R8 precondition in burst");
    rstN = 0; step(1);
    chk(burstFlag, 0, "R8 reset clears burst");
    chk(switchEn, 1, "R8 reset enables switching");
    chk(ssClamp, 0, "R8 reset removes clamp");
    rstN = 1; fbLowRaw = 0; step(2);

    finished = 1;
    summary();
  end
endmodule